// File: doc/BRIEF.md
# PLL Stabilization Wait Sequencer

This block times the lock wait that follows a software request to switch on the primary PLL. An 8-bit up-counter serves as the stabilization timer. Its count clock comes from a prescaler tap picked by a 3-bit select. Software stages two values through a small write port while the sequencer is idle: the select, and the counter start value. It then writes the PLL control register with the primary enable bit set. From that write on, the internal clock is gated off and the external clock pin is switched to the unstable source. The counter runs until it overflows.

A secondary PLL bit may also be set in the same write. In that case the first overflow only switches the secondary PLL on. The counter then reloads the start value that software programmed, and a second, equal period follows. The internal clock resumes only after the final overflow. At that point the timer halts and writes are accepted again. Clearing the primary enable bit switches both PLLs off at once, with no wait.

Top module: `pll_wait_seq`

## Requirements
- R1: After reset, both PLL enables are 0, the clock gate is 1 (clock running), the clock-source select is 1 (stable source), busy is 0 and the timer count is 0x00.
- R2: A write to address 1 loads the start value into the timer count, which is visible on the count output from the next cycle. A write to address 0 sets the division select from bits [2:0]. Address 2 holds the PLL control: bit 0 is the primary enable and bit 1 is the secondary enable.
- R3: Writing address 2 with bit 0 = 1 while the primary PLL is off starts a wait. From the next cycle, the primary enable and busy are 1, and the clock gate and the source select are 0.
- R4: With bit 1 = 0 in the starting write, the clock gate rises exactly (256 - start) * 2^(5+select) cycles after the starting write edge.
- R5: With bit 1 = 1 in the starting write, the secondary enable rises after one such period while the gate stays 0. The gate rises after a second period of the same length, because the counter is reloaded from the start value.
- R6: The clock gate and the source select rise together, and busy falls in the same cycle.
- R7: After the final overflow the count reads 0x00 and holds, because the timer is stopped.
- R8: All writes that arrive while busy is 1 are ignored, including a change of the start value, a change of the select, and a write of 0 to the primary enable. The wait length is unchanged.
- R9: Writing address 2 with bit 0 = 0 while idle clears both PLL enables in the next cycle. The gate stays 1 and busy stays 0.
- R10: Writing address 2 with bit 0 = 1 while the primary PLL is already on starts no wait: busy stays 0 and the gate stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 select, 1 start value, 2 PLL control) |
| wr_data | input | 8 | Write data |
| pll1_en_o | output | 1 | Primary PLL enable |
| pll2_en_o | output | 1 | Secondary PLL enable |
| clk_gate_o | output | 1 | Internal clock enable, 0 while waiting |
| clkout_stable_o | output | 1 | External clock source select, 1 = stable, 0 = unstable |
| busy_o | output | 1 | Wait in progress |
| tmr_count_o | output | 8 | Current timer count |

## Verification
The hardest case to reach is the two-period wait. Here the reload must restore the programmed start value while the prescaler keeps its phase. A wrong reload or a prescaler restart would only show up as a shifted gate edge thousands of cycles later. The table vectors mix select taps, start values and the secondary enable, so the bench checks the exact cycle of each edge of the secondary enable and the gate. One vector also drives disruptive writes halfway through a period, to show that the timing is unaffected.

// File: rtl/pll_wait_pkg.sv
package pll_wait_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned PRE_BASE = 5;
  localparam int unsigned ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_DIVSEL = 2'd0;
  localparam logic [ADDR_W-1:0] A_START  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PLLCTL = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pws_rst_sync.sv
module pws_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/pws_prescaler.sv
module pws_prescaler #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned PRE_BASE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned TAPS  = 2 ** SEL_W;
  localparam int unsigned PRE_W = PRE_BASE + TAPS - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TAPS-1:0]  tap_hit;

  // each tap fires when its low bits are all ones: period 2^(PRE_BASE+i)
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_hit[i] = &pre_q[PRE_BASE+i-1:0];
  end

  always_comb begin
    if (run_i) pre_d = pre_q + 1'b1;
    else       pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = run_i & tap_hit[sel_i];

  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/pws_stab_timer.sv
module pws_stab_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_load_i,
  input  logic [CNT_W-1:0] sw_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic             step;

  assign step  = run_i & tick_i;
  assign ovf_o = step & (&cnt_q);

  always_comb begin
    shadow_d = shadow_q;
    cnt_d    = cnt_q;
    if (sw_load_i) begin
      shadow_d = sw_val_i;
      cnt_d    = sw_val_i;
    end else if (reload_i) begin
      cnt_d = shadow_q;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !sw_load_i) |=> $stable(cnt_q));
  assert_shadow_only_sw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_load_i |=> $stable(shadow_q));
endmodule

// File: rtl/pws_seq_ctrl.sv
module pws_seq_ctrl
  import pll_wait_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic pll2_cfg_i,
  input  logic ovf_i,
  output logic run_o,
  output logic reload_o,
  output logic gate_o,
  output logic src_stable_o,
  output logic pll1_o,
  output logic pll2_o
);
  seq_state_e state_q, state_d;
  logic gate_q, gate_d;
  logic src_q, src_d;
  logic p1_q, p1_d;
  logic p2_q, p2_d;

  always_comb begin
    state_d = state_q;
    gate_d  = gate_q;
    src_d   = src_q;
    p1_d    = p1_q;
    p2_d    = p2_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_WAIT1;
          gate_d  = 1'b0;
          src_d   = 1'b0;
          p1_d    = 1'b1;
        end else if (stop_i) begin
          p1_d = 1'b0;
          p2_d = 1'b0;
        end
      end
      ST_WAIT1: begin
        if (ovf_i) begin
          if (pll2_cfg_i) begin
            state_d = ST_WAIT2;
            p2_d    = 1'b1;
          end else begin
            state_d = ST_IDLE;
            gate_d  = 1'b1;
            src_d   = 1'b1;
          end
        end
      end
      ST_WAIT2: begin
        if (ovf_i) begin
          state_d = ST_IDLE;
          gate_d  = 1'b1;
          src_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b1;
      src_q   <= 1'b1;
      p1_q    <= 1'b0;
      p2_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= gate_d;
      src_q   <= src_d;
      p1_q    <= p1_d;
      p2_q    <= p2_d;
    end
  end

  assign run_o        = (state_q != ST_IDLE);
  assign reload_o     = (state_q == ST_WAIT1) & ovf_i & pll2_cfg_i;
  assign gate_o       = gate_q;
  assign src_stable_o = src_q;
  assign pll1_o       = p1_q;
  assign pll2_o       = p2_q;

  assert_gate_src_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q == src_q);
  assert_halted_while_waiting_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (!gate_q && p1_q));
  assert_resume_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT2 && ovf_i) |=> (gate_q && state_q == ST_IDLE));
  assert_pll2_mid_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p2_q) |-> (state_q == ST_WAIT2));
endmodule

// File: rtl/pll_wait_seq.sv
module pll_wait_seq
  import pll_wait_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pll1_en_o,
  output logic              pll2_en_o,
  output logic              clk_gate_o,
  output logic              clkout_stable_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  tmr_count_o
);
  logic             rst_n_s;
  logic             busy, wr_ok;
  logic             wr_sel, wr_start, wr_pll;
  logic             start, stop;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             p2cfg_q, p2cfg_d;
  logic             tick, ovf, reload;
  logic             p1_on;

  pws_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign wr_ok    = wr_en & ~busy;
  assign wr_sel   = wr_ok & (wr_addr == A_DIVSEL);
  assign wr_start = wr_ok & (wr_addr == A_START);
  assign wr_pll   = wr_ok & (wr_addr == A_PLLCTL);
  assign start    = wr_pll & wr_data[0] & ~p1_on;
  assign stop     = wr_pll & ~wr_data[0];

  always_comb begin
    sel_d   = sel_q;
    p2cfg_d = p2cfg_q;
    if (wr_sel) sel_d   = wr_data[SEL_W-1:0];
    if (wr_pll) p2cfg_d = wr_data[1];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_q   <= '0;
      p2cfg_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      p2cfg_q <= p2cfg_d;
    end
  end

  pws_prescaler #(.SEL_W(SEL_W), .PRE_BASE(PRE_BASE)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .run_i(busy), .sel_i(sel_q), .tick_o(tick)
  );

  pws_stab_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .sw_load_i(wr_start), .sw_val_i(wr_data),
    .run_i(busy), .tick_i(tick), .reload_i(reload), .ovf_o(ovf),
    .cnt_o(tmr_count_o)
  );

  pws_seq_ctrl u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_i(start), .stop_i(stop),
    .pll2_cfg_i(p2cfg_q), .ovf_i(ovf), .run_o(busy), .reload_o(reload),
    .gate_o(clk_gate_o), .src_stable_o(clkout_stable_o),
    .pll1_o(p1_on), .pll2_o(pll2_en_o)
  );

  assign pll1_en_o = p1_on;
  assign busy_o    = busy;

  assert_busy_writes_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && wr_en) |=> ($stable(sel_q) && $stable(p2cfg_q)));
  assert_off_write_immediate_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    stop |=> (!pll1_en_o && !pll2_en_o && clk_gate_o));
endmodule

// File: tb/tb_pll_wait_seq.sv
`timescale 1ns/1ps
module tb_pll_wait_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pll1, pll2, gate, stable, busy;
  logic [7:0] cnt;

  int unsigned checks = 0;
  int unsigned fails  = 0;

  always #5 clk = ~clk;

  pll_wait_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pll1_en_o(pll1), .pll2_en_o(pll2),
    .clk_gate_o(gate), .clkout_stable_o(stable), .busy_o(busy),
    .tmr_count_o(cnt)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  init;
    logic        p2;
    logic        poke;
    logic [15:0] per;   // length of one period in cycles
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hFC, 1'b0, 1'b0, 16'd128},
    '{3'd0, 8'hFC, 1'b1, 1'b0, 16'd128},
    '{3'd2, 8'hFE, 1'b0, 1'b0, 16'd256},
    '{3'd1, 8'hF0, 1'b1, 1'b0, 16'd1024},
    '{3'd7, 8'hFF, 1'b0, 1'b0, 16'd4096},
    '{3'd3, 8'hFD, 1'b1, 1'b1, 16'd768},
    '{3'd0, 8'h00, 1'b0, 1'b0, 16'd8192}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!pll1 && !pll2, "R1 pll", {pll1, pll2}, 0);
    chk(gate && stable, "R1 gate/src", {gate, stable}, 3);
    chk(!busy, "R1 busy", busy, 0);
    chk(cnt == 8'h00, "R1 count", cnt, 0);

    for (int v = 0; v < NV; v++) begin
      automatic int total = VECS[v].p2 ? 2 * VECS[v].per : VECS[v].per;
      automatic int n = 0;
      wr(2'd0, {5'd0, VECS[v].sel});
      wr(2'd1, VECS[v].init);
      chk(cnt == VECS[v].init, "R2 start value load", cnt, VECS[v].init);
      wr(2'd2, {6'd0, VECS[v].p2, 1'b1});
      chk(pll1 && busy && !gate && !stable, "R3 wait entry",
          {pll1, busy, gate, stable}, 4'b1100);
      while (!gate && n <= total + 8) begin
        @(posedge clk); @(negedge clk);
        n++;
        if (VECS[v].poke) begin
          // R8 disruptive writes while busy
          if (n == 10) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00; end
          else if (n == 11) begin wr_addr = 2'd0; wr_data = 8'h07; end
          else if (n == 12) begin wr_addr = 2'd2; wr_data = 8'h00; end
          else if (n == 13) wr_en = 1'b0;
        end
        if (VECS[v].p2 && n == VECS[v].per - 1)
          chk(!pll2, "R5 pll2 before first overflow", pll2, 0);
        if (VECS[v].p2 && n == VECS[v].per)
          chk(pll2 && !gate && busy, "R5 pll2 after first overflow",
              {pll2, gate, busy}, 3'b101);
      end
      chk(n == total, VECS[v].poke ? "R8 wait length with busy writes" :
          (VECS[v].p2 ? "R5 two-period wait" : "R4 single-period wait"), n, total);
      chk(stable && !busy, "R6 source and busy with gate", {stable, busy}, 2);
      chk(cnt == 8'h00, "R7 count after final overflow", cnt, 0);
      repeat (40) @(negedge clk);
      chk(cnt == 8'h00 && gate, "R7 timer held", cnt, 0);

      if (v == 0) begin
        wr(2'd2, 8'h01);
        chk(!busy && gate && pll1, "R10 enable while already on",
            {busy, gate, pll1}, 3'b011);
      end
      wr(2'd2, 8'h00);
      chk(!pll1 && !pll2 && gate && !busy, "R9 immediate off",
          {pll1, pll2, gate, busy}, 4'b0010);
    end

    finish_run();
  end
endmodule